// File: doc/BRIEF.md
# Power-Management Function Configuration and Window Decoder

This block is the configuration side of a power-management function on a PCI-style bus. It holds a 256-byte configuration space, reached through a simple byte-wide write strobe and a combinational read port. Two registers in that space set I/O base addresses: one for a 128-byte power-management register window and one for a 16-byte SMBus window. Each window has its own enable bit, and the block compares every incoming I/O address against both windows and raises a separate hit for each.

Both base registers keep only the address bits above their window size, and bit 0 always reads back as 1. An SMBus control byte keeps only its low nibble. The power-management window claims only single-byte accesses, returns zero on reads and ignores writes.

The block also keeps a 16-bit event status word and a 16-bit event enable word. From these it drives a level-sensitive system control interrupt (SCI) for four event sources. The interrupt is held low whenever the interrupt-pin configuration byte is zero.

Top module: `pmfn_decoder`

## Requirements
- R1: After reset, every configuration byte reads 0x00, with three exceptions: offsets 0x48 and 0x90 read 0x01, and the interrupt-pin byte at offset 0x3D reads 0x01.
- R2: The PM base register is the 32-bit little-endian value at offsets 0x48..0x4B. A write to byte 0x48 stores (data AND 0x80) OR 0x01. Byte 0x49 stores the full byte. Bytes 0x4A and 0x4B always read 0x00.
- R3: The SMBus base register is the 32-bit value at offsets 0x90..0x93. A write to byte 0x90 stores (data AND 0xF0) OR 0x01. Byte 0x91 stores the full byte. Bytes 0x92 and 0x93 always read 0x00.
- R4: A write to the SMBus control byte at offset 0xD2 stores only data bits 3:0. Bits 7:4 read 0.
- R5: Every other byte from 0x40 to 0xFF stores the full written value. Header bytes 0x00..0x3F other than 0x3D read 0x00 and ignore writes. Byte 0x3D stores the full written value.
- R6: pm_hit is 1 exactly when three conditions hold: bit 7 of byte 0x41 is 1, io_single is 1, and io_addr[15:7] equals base bits 15:7 of the PM base register.
- R7: smb_hit is 1 exactly when bit 0 of byte 0xD2 is 1 and io_addr[15:4] equals bits 15:4 of the SMBus base register. The access size has no effect on smb_hit.
- R8: pm_rdata is always 0x00. An access wider than one byte (io_single = 0) never produces pm_hit.
- R9: A 1 on evt_set[i] sets status bit i at the next clock. While pm1_sts_clr is high, each 1 in pm1_wdata clears that status bit. If a bit is set and cleared in the same cycle, the set wins. pm1_en_wr loads the enable word from pm1_wdata.
- R10: sci is 1 when (status AND enable) has a 1 in any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC), and the interrupt-pin byte is nonzero. The other 12 bits never raise sci.
- R11: While the interrupt-pin byte at 0x3D is 0x00, sci stays 0 whatever the status and enable words hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration byte at cfg_addr (combinational) |
| io_addr | input | 16 | I/O address under decode |
| io_single | input | 1 | Access is a single byte |
| pm_hit | output | 1 | Address falls in the enabled PM window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window |
| pm_rdata | output | 8 | Read data of the PM window |
| evt_set | input | 16 | Event pulses that set status bits |
| pm1_sts_clr | input | 1 | Write-one-to-clear strobe for the status word |
| pm1_en_wr | input | 1 | Load strobe for the enable word |
| pm1_wdata | input | 16 | Data for the status clear or the enable load |
| pm1_sts | output | 16 | Current event status word |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The bench writes three patterns into every configuration offset and reads each byte back against a model of the masking rules. A design that masked a base register as a whole word instead of per byte, or dropped the forced bit 0, would show the wrong value at 0x48/0x90 or a nonzero upper base byte. Every one of the 65,536 I/O addresses is decoded with both windows enabled, and the two window regions are decoded again with the windows disabled and with wide accesses. An off-by-one in the compared bit range would widen or shift a window, and a missing enable or size term would produce stray hits. Each of the 16 status bits is raised in turn to confirm that only the four event bits reach sci. Separate cycles cover the interrupt-pin gate, enable masking and a same-cycle set and clear, where a design with clear priority would lose the event.

// File: rtl/pmfn_pkg.sv
package pmfn_pkg;
   localparam int ACPI_TMR_BIT    = 0;
   localparam int ACPI_GBL_BIT    = 5;
   localparam int ACPI_PWRBTN_BIT = 8;
   localparam int ACPI_RTC_BIT    = 10;
   localparam int PM1_W           = 16;
   localparam int IO_AW           = 16;

   typedef logic [PM1_W-1:0] pm1_word_t;

   localparam pm1_word_t SCI_SRC_MASK = pm1_word_t'((1 << ACPI_TMR_BIT) | (1 << ACPI_GBL_BIT) |
                                                    (1 << ACPI_PWRBTN_BIT) | (1 << ACPI_RTC_BIT));

   // Address bits that a window of 2**log2 bytes compares
   function automatic logic [IO_AW-1:0] win_mask(input int log2);
      return {IO_AW{1'b1}} << log2;
   endfunction
endpackage

// File: rtl/pmfn_cfg_space.sv
module pmfn_cfg_space
   import pmfn_pkg::*;
#(
   parameter int         CFG_DEPTH    = 256,
   parameter int         HDR_BYTES    = 64,
   parameter int         INTPIN_OFS   = 'h3D,
   parameter logic [7:0] INTPIN_RST   = 8'h01,
   parameter int         PM_BASE_OFS  = 'h48,
   parameter int         PM_WIN_LOG2  = 7,
   parameter int         PM_EN_OFS    = 'h41,
   parameter int         PM_EN_BIT    = 7,
   parameter int         SMB_BASE_OFS = 'h90,
   parameter int         SMB_WIN_LOG2 = 4,
   parameter int         SMB_CTL_OFS  = 'hD2,
   parameter logic [7:0] SMB_CTL_KEEP = 8'h0F,
   localparam int        CFG_AW       = $clog2(CFG_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [IO_AW-1:0]  pm_base,
   output logic [IO_AW-1:0]  smb_base,
   output logic              pm_win_en,
   output logic              smb_win_en,
   output logic [7:0]        int_pin
);
   localparam logic [IO_AW-1:0] PM_KEEP  = win_mask(PM_WIN_LOG2);
   localparam logic [IO_AW-1:0] SMB_KEEP = win_mask(SMB_WIN_LOG2);

   // Writable bits of each byte
   function automatic logic [7:0] keep_of(input int ofs);
      if (ofs == INTPIN_OFS)                                  return 8'hFF;
      if (ofs < HDR_BYTES)                                    return 8'h00;
      if (ofs == PM_BASE_OFS)                                 return PM_KEEP[7:0];
      if (ofs == PM_BASE_OFS + 1)                             return PM_KEEP[15:8];
      if (ofs == PM_BASE_OFS + 2 || ofs == PM_BASE_OFS + 3)   return 8'h00;
      if (ofs == SMB_BASE_OFS)                                return SMB_KEEP[7:0];
      if (ofs == SMB_BASE_OFS + 1)                            return SMB_KEEP[15:8];
      if (ofs == SMB_BASE_OFS + 2 || ofs == SMB_BASE_OFS + 3) return 8'h00;
      if (ofs == SMB_CTL_OFS)                                 return SMB_CTL_KEEP;
      return 8'hFF;
   endfunction

   // Bits that always read back as 1
   function automatic logic [7:0] force_of(input int ofs);
      if (ofs == PM_BASE_OFS || ofs == SMB_BASE_OFS) return 8'h01;
      return 8'h00;
   endfunction

   function automatic logic [7:0] rst_of(input int ofs);
      if (ofs == INTPIN_OFS) return INTPIN_RST;
      return force_of(ofs);
   endfunction

   if (CFG_DEPTH != (1 << CFG_AW)) begin : g_bad_depth
      $error("CFG_DEPTH must be a power of two");
   end
   if (PM_WIN_LOG2 < 1 || PM_WIN_LOG2 > 15 || SMB_WIN_LOG2 < 1 || SMB_WIN_LOG2 > 15) begin : g_bad_win
      $error("window size log2 must lie in 1..15");
   end
   if (PM_BASE_OFS < HDR_BYTES || PM_BASE_OFS + 3 >= CFG_DEPTH ||
       SMB_BASE_OFS < HDR_BYTES || SMB_BASE_OFS + 3 >= CFG_DEPTH) begin : g_bad_base
      $error("base registers must lie past the header and inside the space");
   end
   if (INTPIN_OFS >= HDR_BYTES || PM_EN_BIT > 7) begin : g_bad_misc
      $error("interrupt pin must be a header byte and the enable bit must be 0..7");
   end

   logic [7:0] bytes_q [CFG_DEPTH];

   for (genvar g = 0; g < CFG_DEPTH; g++) begin : g_byte
      localparam logic [7:0] KEEP  = keep_of(g);
      localparam logic [7:0] FORCE = force_of(g);
      localparam logic [7:0] RST   = rst_of(g);
      if (KEEP == 8'h00) begin : g_const
         assign bytes_q[g] = FORCE;
      end else begin : g_reg
         logic [7:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= RST;
            else if (cfg_we && cfg_addr == CFG_AW'(g))
               r <= (cfg_wdata & KEEP) | FORCE;
         end
         assign bytes_q[g] = r;
      end
   end

   assign cfg_rdata  = bytes_q[cfg_addr];
   assign pm_base    = {bytes_q[PM_BASE_OFS + 1], bytes_q[PM_BASE_OFS]};
   assign smb_base   = {bytes_q[SMB_BASE_OFS + 1], bytes_q[SMB_BASE_OFS]};
   assign pm_win_en  = bytes_q[PM_EN_OFS][PM_EN_BIT];
   assign smb_win_en = bytes_q[SMB_CTL_OFS][0];
   assign int_pin    = bytes_q[INTPIN_OFS];
endmodule

// File: rtl/pmfn_win_dec.sv
module pmfn_win_dec
   import pmfn_pkg::*;
#(
   parameter int WIN_LOG2 = 7
) (
   input  logic [IO_AW-1:0] addr,
   input  logic [IO_AW-1:0] base,
   input  logic             en,
   output logic             hit
);
   localparam logic [IO_AW-1:0] CMP_MASK = win_mask(WIN_LOG2);

   if (WIN_LOG2 < 1 || WIN_LOG2 > 15) begin : g_bad
      $error("WIN_LOG2 out of range");
   end

   assign hit = en && (((addr ^ base) & CMP_MASK) == '0);
endmodule

// File: rtl/pmfn_pm1_events.sv
module pmfn_pm1_events
   import pmfn_pkg::*;
#(
   parameter pm1_word_t SCI_MASK = SCI_SRC_MASK
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pm1_word_t evt_set,
   input  logic      sts_clr,
   input  logic      en_wr,
   input  pm1_word_t wdata,
   input  logic [7:0] int_pin,
   output pm1_word_t sts_q,
   output pm1_word_t en_q,
   output logic      sci
);
   pm1_word_t clr_bits;

   assign clr_bits = sts_clr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= (sts_q & ~clr_bits) | evt_set;
         if (en_wr)
            en_q <= wdata;
      end
   end

   assign sci = (int_pin != 8'h00) && ((sts_q & en_q & SCI_MASK) != '0);
endmodule

// File: rtl/pmfn_decoder.sv
module pmfn_decoder
   import pmfn_pkg::*;
#(
   parameter int         CFG_DEPTH    = 256,
   parameter int         HDR_BYTES    = 64,
   parameter int         INTPIN_OFS   = 'h3D,
   parameter logic [7:0] INTPIN_RST   = 8'h01,
   parameter int         PM_BASE_OFS  = 'h48,
   parameter int         PM_WIN_LOG2  = 7,
   parameter int         PM_EN_OFS    = 'h41,
   parameter int         PM_EN_BIT    = 7,
   parameter int         SMB_BASE_OFS = 'h90,
   parameter int         SMB_WIN_LOG2 = 4,
   parameter int         SMB_CTL_OFS  = 'hD2,
   parameter logic [7:0] SMB_CTL_KEEP = 8'h0F,
   parameter logic [15:0] SCI_MASK    = SCI_SRC_MASK,
   localparam int        CFG_AW       = $clog2(CFG_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [15:0]       io_addr,
   input  logic              io_single,
   output logic              pm_hit,
   output logic              smb_hit,
   output logic [7:0]        pm_rdata,
   input  logic [15:0]       evt_set,
   input  logic              pm1_sts_clr,
   input  logic              pm1_en_wr,
   input  logic [15:0]       pm1_wdata,
   output logic [15:0]       pm1_sts,
   output logic              sci
);
   logic [IO_AW-1:0] pm_base;
   logic [IO_AW-1:0] smb_base;
   logic             pm_win_en;
   logic             smb_win_en;
   logic [7:0]       int_pin;
   logic             pm_match;
   pm1_word_t        pm1_en_q;

   pmfn_cfg_space #(
      .CFG_DEPTH   (CFG_DEPTH),
      .HDR_BYTES   (HDR_BYTES),
      .INTPIN_OFS  (INTPIN_OFS),
      .INTPIN_RST  (INTPIN_RST),
      .PM_BASE_OFS (PM_BASE_OFS),
      .PM_WIN_LOG2 (PM_WIN_LOG2),
      .PM_EN_OFS   (PM_EN_OFS),
      .PM_EN_BIT   (PM_EN_BIT),
      .SMB_BASE_OFS(SMB_BASE_OFS),
      .SMB_WIN_LOG2(SMB_WIN_LOG2),
      .SMB_CTL_OFS (SMB_CTL_OFS),
      .SMB_CTL_KEEP(SMB_CTL_KEEP)
   ) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .pm_base   (pm_base),
      .smb_base  (smb_base),
      .pm_win_en (pm_win_en),
      .smb_win_en(smb_win_en),
      .int_pin   (int_pin)
   );

   pmfn_win_dec #(.WIN_LOG2(PM_WIN_LOG2)) pm_dec_i (
      .addr(io_addr),
      .base(pm_base),
      .en  (pm_win_en),
      .hit (pm_match)
   );

   pmfn_win_dec #(.WIN_LOG2(SMB_WIN_LOG2)) smb_dec_i (
      .addr(io_addr),
      .base(smb_base),
      .en  (smb_win_en),
      .hit (smb_hit)
   );

   // The PM window claims byte accesses only and has no readable content
   assign pm_hit   = pm_match && io_single;
   assign pm_rdata = 8'h00;

   pmfn_pm1_events #(.SCI_MASK(SCI_MASK)) evt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_set(evt_set),
      .sts_clr(pm1_sts_clr),
      .en_wr  (pm1_en_wr),
      .wdata  (pm1_wdata),
      .int_pin(int_pin),
      .sts_q  (pm1_sts),
      .en_q   (pm1_en_q),
      .sci    (sci)
   );
endmodule

// File: rtl/pmfn_decoder_chk.sv
module pmfn_decoder_chk #(
   parameter int          PM_WIN_LOG2  = 7,
   parameter int          SMB_WIN_LOG2 = 4,
   parameter logic [15:0] SCI_MASK     = 16'h0521
) (
   input logic        clk,
   input logic        rst_n,
   input logic        io_single,
   input logic        pm_hit,
   input logic        smb_hit,
   input logic [15:0] pm_base,
   input logic [15:0] smb_base,
   input logic        pm_win_en,
   input logic        smb_win_en,
   input logic [7:0]  int_pin,
   input logic [15:0] evt_set,
   input logic [15:0] pm1_sts,
   input logic [15:0] pm1_en,
   input logic        sci
);
   localparam logic [15:0] PM_LOW  = ~(16'hFFFF << PM_WIN_LOG2);
   localparam logic [15:0] SMB_LOW = ~(16'hFFFF << SMB_WIN_LOG2);

   // R2: stored PM base below the window size is always exactly 1
   a_r2_pm_base_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_base & PM_LOW) == 16'h0001);

   // R3: same rule for the SMBus base
   a_r3_smb_base_low: assert property (@(posedge clk) disable iff (!rst_n)
      (smb_base & SMB_LOW) == 16'h0001);

   // R6 / R8: PM hit needs the enable bit and a byte access
   a_r6_pm_hit_gate: assert property (@(posedge clk) disable iff (!rst_n)
      pm_hit |-> (pm_win_en && io_single));

   // R7: SMBus hit needs its enable bit
   a_r7_smb_hit_gate: assert property (@(posedge clk) disable iff (!rst_n)
      smb_hit |-> smb_win_en);

   // R9: an event pulse is visible in status on the next cycle
   a_r9_evt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_set) |=> ((pm1_sts & $past(evt_set)) == $past(evt_set)));

   // R10: sci only with an enabled pending event source
   a_r10_sci_source: assert property (@(posedge clk) disable iff (!rst_n)
      sci |-> ((pm1_sts & pm1_en & SCI_MASK) != 16'h0000));

   // R11: zero interrupt pin keeps sci low
   a_r11_sci_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (int_pin == 8'h00) |-> !sci);
endmodule

bind pmfn_decoder pmfn_decoder_chk #(
   .PM_WIN_LOG2 (PM_WIN_LOG2),
   .SMB_WIN_LOG2(SMB_WIN_LOG2),
   .SCI_MASK    (SCI_MASK)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_single (io_single),
   .pm_hit    (pm_hit),
   .smb_hit   (smb_hit),
   .pm_base   (pm_base),
   .smb_base  (smb_base),
   .pm_win_en (pm_win_en),
   .smb_win_en(smb_win_en),
   .int_pin   (int_pin),
   .evt_set   (evt_set),
   .pm1_sts   (pm1_sts),
   .pm1_en    (pm1_en_q),
   .sci       (sci)
);

// File: tb/pmfn_decoder_tb_top.sv
module pmfn_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [15:0] io_addr = '0;
   logic        io_single = 1'b1;
   logic        pm_hit;
   logic        smb_hit;
   logic [7:0]  pm_rdata;
   logic [15:0] evt_set = '0;
   logic        pm1_sts_clr = 1'b0;
   logic        pm1_en_wr = 1'b0;
   logic [15:0] pm1_wdata = '0;
   logic [15:0] pm1_sts;
   logic        sci;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   logic [7:0] mdl [256];

   always #5 clk = ~clk;

   pmfn_decoder dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .io_addr(io_addr), .io_single(io_single), .pm_hit(pm_hit), .smb_hit(smb_hit),
      .pm_rdata(pm_rdata), .evt_set(evt_set), .pm1_sts_clr(pm1_sts_clr),
      .pm1_en_wr(pm1_en_wr), .pm1_wdata(pm1_wdata), .pm1_sts(pm1_sts), .sci(sci)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] stored(input int ofs, input logic [7:0] d);
      if (ofs == 'h3D) return d;
      if (ofs < 'h40) return 8'h00;
      case (ofs)
         'h48:             return (d & 8'h80) | 8'h01;
         'h4A, 'h4B:       return 8'h00;
         'h90:             return (d & 8'hF0) | 8'h01;
         'h92, 'h93:       return 8'h00;
         'hD2:             return d & 8'h0F;
         default:          return d;
      endcase
   endfunction

   function automatic string req_of(input int ofs);
      if (ofs >= 'h48 && ofs <= 'h4B) return "R2";
      if (ofs >= 'h90 && ofs <= 'h93) return "R3";
      if (ofs == 'hD2) return "R4";
      return "R5";
   endfunction

   task automatic cfg_wr(input int ofs, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'(ofs); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      mdl[ofs] = stored(ofs, d);
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < 256; i++) begin
         cfg_addr = 8'(i);
         #1;
         chk((tag == "") ? req_of(i) : tag, {24'h0, cfg_rdata}, {24'h0, mdl[i]});
      end
   endtask

   task automatic pm1_step(input logic [15:0] set, input logic clr, input logic enw,
                           input logic [15:0] wd);
      @(negedge clk);
      evt_set = set; pm1_sts_clr = clr; pm1_en_wr = enw; pm1_wdata = wd;
      @(negedge clk);
      evt_set = '0; pm1_sts_clr = 1'b0; pm1_en_wr = 1'b0;
   endtask

   task automatic sweep_io(input int lo, input int hi, input logic single,
                           input logic pm_on, input logic smb_on,
                           input logic [15:0] pmb, input logic [15:0] smbb);
      io_single = single;
      for (int a = lo; a <= hi; a++) begin
         logic exp_pm, exp_smb;
         io_addr = 16'(a);
         #1;
         exp_pm  = pm_on && single && (a[15:7] == pmb[15:7]);
         exp_smb = smb_on && (a[15:4] == smbb[15:4]);
         chk("R6", {31'h0, pm_hit}, {31'h0, exp_pm});
         chk("R7", {31'h0, smb_hit}, {31'h0, exp_smb});
         if (exp_pm || a[7:0] == 8'h00)
            chk("R8", {24'h0, pm_rdata}, 32'h0);
      end
      io_single = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
      mdl['h48] = 8'h01; mdl['h90] = 8'h01; mdl['h3D] = 8'h01;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset contents, outputs idle
      read_all("R1");
      chk("R1", {16'h0, pm1_sts}, 32'h0);
      chk("R11", {31'h0, sci}, 32'h0);

      // R2..R5: three write patterns over the whole space
      for (int i = 0; i < 256; i++) cfg_wr(i, 8'((i * 7 + 3) ^ 8'h5A));
      read_all("");
      for (int i = 0; i < 256; i++) cfg_wr(i, 8'hFF);
      read_all("");
      for (int i = 0; i < 256; i++) cfg_wr(i, 8'h00);
      read_all("");

      // R6 R7 R8: full address sweep with both windows on
      cfg_wr('h48, 8'h80); cfg_wr('h49, 8'h1A);
      cfg_wr('h90, 8'h5F); cfg_wr('h91, 8'h3C);
      cfg_wr('h41, 8'h80); cfg_wr('hD2, 8'hF1);
      sweep_io(0, 65535, 1'b1, 1'b1, 1'b1, 16'h1A80, 16'h3C50);
      // R8: wide accesses never hit the PM window, SMBus still decodes
      sweep_io('h1A00, 'h1BFF, 1'b0, 1'b1, 1'b1, 16'h1A80, 16'h3C50);
      sweep_io('h3C00, 'h3CFF, 1'b0, 1'b1, 1'b1, 16'h1A80, 16'h3C50);
      // R6 R7: enables cleared
      cfg_wr('h41, 8'h7F); cfg_wr('hD2, 8'hFE);
      sweep_io('h1A00, 'h1BFF, 1'b1, 1'b0, 1'b0, 16'h1A80, 16'h3C50);
      sweep_io('h3C00, 'h3CFF, 1'b1, 1'b0, 1'b0, 16'h1A80, 16'h3C50);

      // R9 R10: each status bit in turn with all enables on
      cfg_wr('h3D, 8'h01);
      pm1_step('0, 1'b0, 1'b1, 16'hFFFF);
      for (int b = 0; b < 16; b++) begin
         logic [15:0] bit_v;
         bit_v = 16'(1 << b);
         pm1_step(bit_v, 1'b0, 1'b0, '0);
         chk("R9", {16'h0, pm1_sts}, {16'h0, bit_v});
         chk("R10", {31'h0, sci}, {31'h0, (16'h0521 & bit_v) != 0});
         pm1_step('0, 1'b1, 1'b0, bit_v);
         chk("R9", {16'h0, pm1_sts}, 32'h0);
         chk("R10", {31'h0, sci}, 32'h0);
      end

      // R9: set beats clear in the same cycle; clear leaves other bits
      pm1_step(16'h0021, 1'b0, 1'b0, '0);
      pm1_step(16'h0020, 1'b1, 1'b0, 16'h0021);
      chk("R9", {16'h0, pm1_sts}, 32'h0020);
      pm1_step('0, 1'b1, 1'b0, 16'hFFFF);
      chk("R9", {16'h0, pm1_sts}, 32'h0);

      // R10: enable masking
      pm1_step('0, 1'b0, 1'b1, 16'h0100);
      pm1_step(16'h0001, 1'b0, 1'b0, '0);
      chk("R10", {31'h0, sci}, 32'h0);
      pm1_step(16'h0100, 1'b0, 1'b0, '0);
      chk("R10", {31'h0, sci}, 32'h1);

      // R11: zero interrupt pin blocks sci, restoring it re-enables
      cfg_wr('h3D, 8'h00);
      chk("R11", {31'h0, sci}, 32'h0);
      pm1_step(16'hFFFF, 1'b0, 1'b1, 16'hFFFF);
      chk("R11", {31'h0, sci}, 32'h0);
      cfg_wr('h3D, 8'h04);
      chk("R10", {31'h0, sci}, 32'h1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule